// File: doc/BRIEF.md
# Time-Code Master/Slave Controller

This block owns the 8-bit time value of a multi-port switch and decides when a time-code is sent to the ports. As master, it turns the rising edge of an asynchronous external tick into a new time-code. The new code is either the register advanced by one or an external value that is loaded verbatim. Every port then gets a one-cycle send strobe carrying the new code.

As slave, it looks at each code received on any port. A code that is exactly one step ahead of the register is accepted. It is sent out of every port except the one it arrived on, and it is reported on an active-low external tick-out together with its value. Any other received code only overwrites the register. Nothing is sent and no tick-out is raised. This stops a code from looping for ever through a ring in the network.

Time values are 8 bits wide. The low 6 bits form a counter that wraps modulo 64. The top 2 bits are flags that are carried along unchanged. A clear input forces the register to zero.

Top module: `tc_hub`

## Requirements
- R1: While `rst` is high, and at the first sample after it, `time_now` is 0, `tx_send` is 0, `ext_tick_out_n` is 1 and `ext_time_out` is 0.
- R2: When `master_mode`=1 and `ext_load_sel`=0, a rising edge on `ext_tick_in` has the following effect 3 clock edges later. Bits [5:0] of the register are incremented modulo 64, bits [7:6] are kept, and `tx_send` is all ones for exactly one cycle with `tx_code` equal to the new value. Holding the tick high produces no further send.
- R3: When `master_mode`=1 and `ext_load_sel`=1 at the edge where the tick rise takes effect, `ext_time_in` is loaded unchanged into the register. It is sent on all ports in the same way as in R2.
- R4: `cnt_clear` high at an edge sets `time_now` to 0 at that edge. It wins over a tick rise or a received code in the same cycle, so no send and no tick-out result.
- R5: When `master_mode`=0, a code with `rx_valid`=1 is valid if `rx_code[5:0]` equals (`time_now[5:0]`+1) mod 64. After the next edge, the register holds `rx_code`, `tx_code`=`rx_code`, and `tx_send` has every bit set except bit `rx_port`, for one cycle.
- R6: When `master_mode`=0, a received code that is not valid still loads the register with `rx_code`. `tx_send` stays 0 and `ext_tick_out_n` stays 1.
- R7: A valid received code drives `ext_tick_out_n` low for one cycle after the edge that accepts it. `ext_time_out` then equals the code and keeps that value until the next valid code.
- R8: In master mode, received codes have no effect. In slave mode, `ext_tick_in` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| master_mode | input | 1 | 1 = generate codes from the external tick, 0 = check and forward received codes |
| ext_tick_in | input | 1 | Asynchronous external tick; its rising edge requests a code |
| ext_load_sel | input | 1 | When high, a tick loads `ext_time_in` instead of incrementing |
| ext_time_in | input | 8 | External time value for load |
| cnt_clear | input | 1 | Clears the time register |
| rx_valid | input | 1 | A code was received this cycle |
| rx_port | input | 2 | Index of the port that received the code |
| rx_code | input | 8 | Received time-code |
| tx_send | output | 4 | One-cycle send strobe per port |
| tx_code | output | 8 | Code to send with `tx_send` |
| ext_tick_out_n | output | 1 | Active-low tick-out for accepted codes |
| ext_time_out | output | 8 | Last accepted received code |
| time_now | output | 8 | Current time register |

## Verification
Two functions can act on the register in the same cycle: the clear, and the event that would otherwise update the register. That event is a synchronised tick rise in master mode, or a received code in slave mode. The bench provokes both pairings. For the tick case, it raises the tick, waits the two synchroniser edges, then drives the clear into exactly the edge where the rise acts. For the received-code case, it drives a valid code together with the clear. Either collision is judged correct only if the register reads zero afterwards, with no send strobe and no tick-out. A later held-high tick must then also produce no send, which shows that the rise was consumed.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic {
    TC_SLAVE  = 1'b0,
    TC_MASTER = 1'b1
  } tc_mode_e;
endpackage

// File: rtl/tc_edge_sync.sv
module tc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= async_in;
    end
  end else begin : g_many
    always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], async_in};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain_q[STAGES-1];
  end

  assign rise = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tc_time_core.sv
module tc_time_core
  import tc_pkg::*;
#(
  parameter int TIME_W = 8,
  parameter int CNT_W  = 6,
  parameter int PORT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master_mode,
  input  logic              tick_rise,
  input  logic              load_sel,
  input  logic [TIME_W-1:0] load_val,
  input  logic              clear,
  input  logic              rx_valid,
  input  logic [PORT_W-1:0] rx_port,
  input  logic [TIME_W-1:0] rx_code,
  output logic              fire,
  output logic              fire_all,
  output logic [PORT_W-1:0] fire_src,
  output logic [TIME_W-1:0] time_q,
  output logic [TIME_W-1:0] code_q,
  output logic              tick_n_q,
  output logic [TIME_W-1:0] ext_val_q
);
  localparam int FLAG_W = TIME_W - CNT_W;

  tc_mode_e          mode;
  logic [CNT_W-1:0]  cnt_next;
  logic              rx_match;
  logic              slave_ok;
  logic [TIME_W-1:0] time_d;

  assign mode     = tc_mode_e'(master_mode);
  assign cnt_next = time_q[CNT_W-1:0] + {{(CNT_W-1){1'b0}}, 1'b1};
  assign rx_match = (rx_code[CNT_W-1:0] == cnt_next);
  assign fire_src = rx_port;

  always_comb begin
    time_d   = time_q;
    fire     = 1'b0;
    fire_all = 1'b0;
    slave_ok = 1'b0;
    if (clear) begin
      time_d = '0;
    end else if (mode == TC_MASTER) begin
      if (tick_rise) begin
        fire     = 1'b1;
        fire_all = 1'b1;
        time_d   = load_sel ? load_val : {time_q[TIME_W-1 -: FLAG_W], cnt_next};
      end
    end else if (rx_valid) begin
      time_d = rx_code;
      if (rx_match) begin
        fire     = 1'b1;
        slave_ok = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      time_q    <= '0;
      code_q    <= '0;
      tick_n_q  <= 1'b1;
      ext_val_q <= '0;
    end else begin
      time_q   <= time_d;
      tick_n_q <= ~slave_ok;
      if (fire)     code_q    <= time_d;
      if (slave_ok) ext_val_q <= rx_code;
    end
  end
endmodule

// File: rtl/tc_fanout.sv
module tc_fanout #(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fire,
  input  logic                 fire_all,
  input  logic [PORT_W-1:0]    src,
  output logic [NUM_PORTS-1:0] send_q
);
  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) send_q[g] <= 1'b0;
      else     send_q[g] <= fire & (fire_all | (src != PORT_W'(g)));
    end
  end
endmodule

// File: rtl/tc_hub.sv
module tc_hub #(
  parameter int NUM_PORTS   = 4,
  parameter int TIME_W      = 8,
  parameter int CNT_W       = 6,
  parameter int SYNC_STAGES = 2,
  localparam int PORT_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 master_mode,
  input  logic                 ext_tick_in,
  input  logic                 ext_load_sel,
  input  logic [TIME_W-1:0]    ext_time_in,
  input  logic                 cnt_clear,
  input  logic                 rx_valid,
  input  logic [PORT_W-1:0]    rx_port,
  input  logic [TIME_W-1:0]    rx_code,
  output logic [NUM_PORTS-1:0] tx_send,
  output logic [TIME_W-1:0]    tx_code,
  output logic                 ext_tick_out_n,
  output logic [TIME_W-1:0]    ext_time_out,
  output logic [TIME_W-1:0]    time_now
);
  logic              tick_rise;
  logic              fire;
  logic              fire_all;
  logic [PORT_W-1:0] fire_src;

  tc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (ext_tick_in),
    .rise     (tick_rise)
  );

  tc_time_core #(.TIME_W(TIME_W), .CNT_W(CNT_W), .PORT_W(PORT_W)) u_core (
    .clk         (clk),
    .rst         (rst),
    .master_mode (master_mode),
    .tick_rise   (tick_rise),
    .load_sel    (ext_load_sel),
    .load_val    (ext_time_in),
    .clear       (cnt_clear),
    .rx_valid    (rx_valid),
    .rx_port     (rx_port),
    .rx_code     (rx_code),
    .fire        (fire),
    .fire_all    (fire_all),
    .fire_src    (fire_src),
    .time_q      (time_now),
    .code_q      (tx_code),
    .tick_n_q    (ext_tick_out_n),
    .ext_val_q   (ext_time_out)
  );

  tc_fanout #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_fan (
    .clk      (clk),
    .rst      (rst),
    .fire     (fire),
    .fire_all (fire_all),
    .src      (fire_src),
    .send_q   (tx_send)
  );
endmodule

// File: rtl/tc_hub_chk.sv
module tc_hub_chk #(
  parameter int NUM_PORTS = 4,
  parameter int TIME_W    = 8,
  parameter int PORT_W    = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 master_mode,
  input logic                 cnt_clear,
  input logic                 rx_valid,
  input logic [PORT_W-1:0]    rx_port,
  input logic [TIME_W-1:0]    rx_code,
  input logic [NUM_PORTS-1:0] tx_send,
  input logic [TIME_W-1:0]    tx_code,
  input logic                 ext_tick_out_n,
  input logic [TIME_W-1:0]    ext_time_out,
  input logic [TIME_W-1:0]    time_now
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (tx_send == '0 && ext_tick_out_n && time_now == '0)); // R1

  AST_MASTER_ALL_PORTS: assert property (@(posedge clk) disable iff (rst)
    (tx_send != '0 && ext_tick_out_n) |-> (tx_send == '1)); // R2

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    $past(cnt_clear) |-> (time_now == '0 && tx_send == '0 && ext_tick_out_n)); // R4

  AST_SKIP_SOURCE: assert property (@(posedge clk) disable iff (rst)
    !ext_tick_out_n |-> ((tx_send & (NUM_PORTS'(1) << $past(rx_port))) == '0)); // R5

  AST_SLAVE_TRACKS: assert property (@(posedge clk) disable iff (rst)
    ($past(rx_valid) && !$past(master_mode) && !$past(cnt_clear)) |-> (time_now == $past(rx_code))); // R6

  AST_TICKOUT_VALUE: assert property (@(posedge clk) disable iff (rst)
    !ext_tick_out_n |-> (ext_time_out == time_now && tx_code == ext_time_out)); // R7

  AST_TICKOUT_SOURCE: assert property (@(posedge clk) disable iff (rst)
    !ext_tick_out_n |-> ($past(rx_valid) && !$past(master_mode))); // R8
endmodule

bind tc_hub tc_hub_chk #(.NUM_PORTS(NUM_PORTS), .TIME_W(TIME_W), .PORT_W(PORT_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .master_mode    (master_mode),
  .cnt_clear      (cnt_clear),
  .rx_valid       (rx_valid),
  .rx_port        (rx_port),
  .rx_code        (rx_code),
  .tx_send        (tx_send),
  .tx_code        (tx_code),
  .ext_tick_out_n (ext_tick_out_n),
  .ext_time_out   (ext_time_out),
  .time_now       (time_now)
);

// File: tb/tc_hub_test.sv
module tc_hub_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       master_mode = 1'b0;
  logic       ext_tick_in = 1'b0;
  logic       ext_load_sel = 1'b0;
  logic [7:0] ext_time_in = '0;
  logic       cnt_clear = 1'b0;
  logic       rx_valid = 1'b0;
  logic [1:0] rx_port = '0;
  logic [7:0] rx_code = '0;
  logic [3:0] tx_send;
  logic [7:0] tx_code;
  logic       ext_tick_out_n;
  logic [7:0] ext_time_out;
  logic [7:0] time_now;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] exp_time = '0;
  logic [7:0] exp_ext  = '0;

  always #10 clk = ~clk;

  tc_hub uut (
    .clk(clk), .rst(rst), .master_mode(master_mode), .ext_tick_in(ext_tick_in),
    .ext_load_sel(ext_load_sel), .ext_time_in(ext_time_in), .cnt_clear(cnt_clear),
    .rx_valid(rx_valid), .rx_port(rx_port), .rx_code(rx_code), .tx_send(tx_send),
    .tx_code(tx_code), .ext_tick_out_n(ext_tick_out_n), .ext_time_out(ext_time_out),
    .time_now(time_now)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic master_tick(input logic sel, input logic [7:0] val, input string tag);
    logic [7:0] nv;
    ext_load_sel = sel;
    ext_time_in  = val;
    ext_tick_in  = 1'b1;
    step();
    chk({tag, " no early send 1"}, 32'(tx_send), 32'h0);
    step();
    chk({tag, " no early send 2"}, 32'(tx_send), 32'h0);
    step();
    nv = sel ? val : {exp_time[7:6], exp_time[5:0] + 6'd1};
    exp_time = nv;
    chk({tag, " send all"}, 32'(tx_send), 32'hF);
    chk({tag, " code"}, 32'(tx_code), 32'(nv));
    chk({tag, " time"}, 32'(time_now), 32'(nv));
    chk({tag, " no tickout"}, 32'(ext_tick_out_n), 32'h1);
    step();
    chk({tag, " one pulse while held"}, 32'(tx_send), 32'h0);
    ext_tick_in = 1'b0;
    step(); step(); step();
    chk({tag, " no send on fall"}, 32'(tx_send), 32'h0);
  endtask

  // slave-mode receive with expectation from R5/R6/R7
  task automatic slave_rx(input logic [7:0] code, input logic [1:0] port);
    logic ok;
    ok = (code[5:0] == (exp_time[5:0] + 6'd1));
    rx_valid = 1'b1;
    rx_code  = code;
    rx_port  = port;
    step();
    rx_valid = 1'b0;
    exp_time = code;
    if (ok) begin
      exp_ext = code;
      chk("R5 send mask", 32'(tx_send), 32'(4'hF & ~(4'b1 << port)));
      chk("R5 code", 32'(tx_code), 32'(code));
      chk("R7 tickout low", 32'(ext_tick_out_n), 32'h0);
      chk("R7 time out", 32'(ext_time_out), 32'(code));
    end else begin
      chk("R6 no send", 32'(tx_send), 32'h0);
      chk("R6 no tickout", 32'(ext_tick_out_n), 32'h1);
    end
    chk("R5 R6 register", 32'(time_now), 32'(code));
    step();
    chk("R7 tickout one cycle", 32'(ext_tick_out_n), 32'h1);
    chk("R5 pulse one cycle", 32'(tx_send), 32'h0);
    chk("R7 time out holds", 32'(ext_time_out), 32'(exp_ext));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step(); step();
    chk("R1 time in reset", 32'(time_now), 32'h0);
    chk("R1 send in reset", 32'(tx_send), 32'h0);
    chk("R1 tickout in reset", 32'(ext_tick_out_n), 32'h1);
    chk("R1 ext time in reset", 32'(ext_time_out), 32'h0);
    rst = 1'b0;
    master_mode = 1'b1;
    step();
    chk("R1 time after reset", 32'(time_now), 32'h0);

    // R3: load with flags, then R2 sweep across the modulo-64 wrap
    master_tick(1'b1, 8'hC5, "R3 load");
    for (int i = 0; i < 66; i++) master_tick(1'b0, 8'h00, "R2 auto");
    master_tick(1'b1, 8'h3F, "R3 load 3F");
    master_tick(1'b0, 8'h00, "R2 wrap no flags");
    master_tick(1'b1, 8'h7E, "R3 load 7E");
    master_tick(1'b0, 8'hFF, "R2 ignores ext value");

    // R8: received codes ignored in master mode
    rx_valid = 1'b1; rx_code = {exp_time[7:6], exp_time[5:0] + 6'd1}; rx_port = 2'd1;
    step();
    rx_valid = 1'b0;
    chk("R8 master ignores rx time", 32'(time_now), 32'(exp_time));
    chk("R8 master ignores rx send", 32'(tx_send), 32'h0);
    chk("R8 master ignores rx tickout", 32'(ext_tick_out_n), 32'h1);

    // R8: tick ignored in slave mode
    master_mode = 1'b0;
    ext_tick_in = 1'b1;
    step(); step(); step(); step();
    chk("R8 slave ignores tick time", 32'(time_now), 32'(exp_time));
    chk("R8 slave ignores tick send", 32'(tx_send), 32'h0);
    ext_tick_in = 1'b0;
    step(); step(); step();

    // R5/R6/R7 sweep over base values, ports and flags
    for (int b = 0; b < 64; b++) begin
      slave_rx({2'(b), 6'((b * 7) % 64)}, 2'(b % 4));
      for (int p = 0; p < 4; p++)
        slave_rx({2'(b + p), exp_time[5:0] + 6'd1}, 2'(p));
      slave_rx({exp_time[7:6], exp_time[5:0] + 6'd2}, 2'(b % 4));
      slave_rx(exp_time, 2'((b + 1) % 4));
    end

    // R4: clear alone, and in collision with a valid received code
    cnt_clear = 1'b1;
    step();
    cnt_clear = 1'b0;
    exp_time = 8'h00;
    chk("R4 clear", 32'(time_now), 32'h0);
    slave_rx(8'h05, 2'd0);
    rx_valid = 1'b1; rx_code = 8'h06; rx_port = 2'd2; cnt_clear = 1'b1;
    step();
    rx_valid = 1'b0; cnt_clear = 1'b0;
    exp_time = 8'h00;
    chk("R4 clear beats rx time", 32'(time_now), 32'h0);
    chk("R4 clear beats rx send", 32'(tx_send), 32'h0);
    chk("R4 clear beats rx tickout", 32'(ext_tick_out_n), 32'h1);
    slave_rx(8'h01, 2'd3);

    // R4: clear at the same edge as a master tick rise
    master_mode = 1'b1;
    ext_load_sel = 1'b0;
    ext_tick_in = 1'b1;
    step(); step();
    cnt_clear = 1'b1;
    step();
    cnt_clear = 1'b0;
    exp_time = 8'h00;
    chk("R4 clear beats tick time", 32'(time_now), 32'h0);
    chk("R4 clear beats tick send", 32'(tx_send), 32'h0);
    step(); step();
    chk("R4 rise consumed", 32'(tx_send), 32'h0);
    ext_tick_in = 1'b0;
    step(); step(); step();
    master_tick(1'b0, 8'h00, "R2 after clear");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule